// File: doc/BRIEF.md
# Two-Way Region-Tagged Page Translator

This block turns a 23-bit virtual byte address into a 15-bit physical address inside a small local page memory. The address is read as three fields: the top five bits name one of 32 coarse regions (256 KB each), the next nine bits select one of 512 translation sets, and the low nine bits are the offset inside a 512-byte page. Each set holds two slots, so two pages that share a set number but come from different regions can be resident together. Each slot keeps a valid bit, the region tag, a 6-bit frame number, a saturating use counter, a modified (dirty) flag and a pinned (lock) flag.

A request is answered one clock later. A hit returns the frame number joined with the offset. A miss raises a one-cycle fault that carries the region and set number. At the same time the block names the slot that the incoming page should replace, whether that slot holds modified data, and its frame. It then ignores new requests until a refill arrives. The refill writes the new page into the named slot. Within each set, the more-used page is kept in slot 0, which is probed first.

Top module: `pxu_translate`

## Requirements
- R1: The address is split MSB to LSB as tag[22:18], set[17:9], offset[8:0]. A request accepted on a clock edge gives rsp_valid on the next cycle. On a hit, rsp_paddr = {frame[5:0], offset[8:0]} and rsp_hit=1. Exactly one of rsp_hit and rsp_fault is high with rsp_valid.
- R2: A miss gives rsp_fault for one cycle with fault_tag and fault_index, and sets busy. While busy is high, requests get no response.
- R3: A refill while busy writes valid=1, the faulted tag, refill_frame, counter 0, dirty 0 and lock=refill_lock into the named slot, and clears busy. A later request to that page hits.
- R4: Two pages with the same set number but different tags are resident at once and both hit.
- R5: Each hit adds one to the hit slot's 3-bit use counter, which stops at 7.
- R6: A hit with req_write=1 sets that slot's dirty flag. When the named victim is valid and dirty, victim_wb=1 and victim_frame is its frame.
- R7: Victim choice on a miss: an empty slot first, slot 0 before slot 1. Otherwise the slot with the lower counter. On equal counters, the slot that was not refilled most recently in that set.
- R8: A locked slot is never named as victim. If both slots are valid and locked, victim_none=1 with victim_slot=0 and victim_wb=0. The following refill then only clears busy and writes nothing.
- R9: When a hit in slot 1 leaves its counter above slot 0's, the two slots swap places. rsp_slot reports the slot that hit, before the swap.
- R10: Reset clears all valid bits and all outputs. A refill while not busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_write | input | 1 | Request is a store |
| req_addr | input | 23 | Virtual byte address |
| refill_valid | input | 1 | Refill strobe for the pending fault |
| refill_frame | input | 6 | Frame number of the loaded page |
| refill_lock | input | 1 | Pin the loaded page |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Page was resident |
| rsp_fault | output | 1 | Page was not resident |
| rsp_slot | output | 1 | Slot that hit |
| rsp_paddr | output | 15 | Physical address on a hit |
| fault_tag | output | 5 | Region of the last fault |
| fault_index | output | 9 | Set of the last fault |
| busy | output | 1 | Waiting for a refill |
| victim_slot | output | 1 | Slot to be replaced |
| victim_none | output | 1 | Both slots are pinned |
| victim_wb | output | 1 | Victim holds modified data |
| victim_frame | output | 6 | Frame of the victim |

## Verification
The stimulus first fills one set from empty and then runs repeated reads and writes to the same page. This separates the empty-slot preference from the counter rule, and shows that writes mark pages dirty. Next come sequences that build up equal counters, including counters pushed past saturation. These show whether ties are broken on which slot was refilled last, and whether an overflowing counter wraps. Further cases pin one slot and then both, refill while idle, and request while busy, so that the ignored inputs can be seen at the ports. A long mixed run with random tags, sets and writes over a few sets ends the test, and a behavioural model checks every output on every clock.

// File: rtl/pxu_pkg.sv
package pxu_pkg;
    localparam int TAG_W = 5;
    localparam int IDX_W = 9;
    localparam int OFF_W = 9;
    localparam int FRM_W = 6;
    localparam int CNT_W = 3;

    typedef struct packed {
        logic             valid;
        logic             lock;
        logic             dirty;
        logic [TAG_W-1:0] tag;
        logic [FRM_W-1:0] frame;
        logic [CNT_W-1:0] cnt;
    } slot_t;
endpackage

// File: rtl/pxu_probe.sv
module pxu_probe
    import pxu_pkg::*;
(
    input  slot_t            s0,
    input  slot_t            s1,
    input  logic [TAG_W-1:0] tag,
    output logic             hit,
    output logic             slot
);
    logic m0, m1;
    always_comb begin
        m0   = s0.valid && (s0.tag == tag);
        m1   = s1.valid && (s1.tag == tag);
        hit  = m0 || m1;
        slot = !m0 && m1;
    end
endmodule

// File: rtl/pxu_victim.sv
module pxu_victim
    import pxu_pkg::*;
(
    input  slot_t            s0,
    input  slot_t            s1,
    input  logic             last_fill,
    output logic             slot,
    output logic             none,
    output logic             wb,
    output logic [FRM_W-1:0] frame
);
    slot_t pick;
    always_comb begin
        none = 1'b0;
        if (!s0.valid)                slot = 1'b0;
        else if (!s1.valid)           slot = 1'b1;
        else if (s0.lock && s1.lock) begin
            slot = 1'b0;
            none = 1'b1;
        end
        else if (s0.lock)             slot = 1'b1;
        else if (s1.lock)             slot = 1'b0;
        else if (s0.cnt < s1.cnt)     slot = 1'b0;
        else if (s1.cnt < s0.cnt)     slot = 1'b1;
        else                          slot = ~last_fill;
        pick  = slot ? s1 : s0;
        wb    = !none && pick.valid && pick.dirty;
        frame = (!none && pick.valid) ? pick.frame : '0;
    end
endmodule

// File: rtl/pxu_translate.sv
module pxu_translate
    import pxu_pkg::*;
#(
    localparam int VA_W = TAG_W + IDX_W + OFF_W,
    localparam int PA_W = FRM_W + OFF_W,
    localparam int SETS = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [VA_W-1:0]  req_addr,
    input  logic             refill_valid,
    input  logic [FRM_W-1:0] refill_frame,
    input  logic             refill_lock,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_fault,
    output logic             rsp_slot,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic [TAG_W-1:0] fault_tag,
    output logic [IDX_W-1:0] fault_index,
    output logic             busy,
    output logic             victim_slot,
    output logic             victim_none,
    output logic             victim_wb,
    output logic [FRM_W-1:0] victim_frame
);
    typedef struct packed {
        logic             busy;
        logic             rv;
        logic             hit;
        logic             fault;
        logic             slot;
        logic [PA_W-1:0]  paddr;
        logic [TAG_W-1:0] ftag;
        logic [IDX_W-1:0] fidx;
        logic             vslot;
        logic             vnone;
        logic             vwb;
        logic [FRM_W-1:0] vframe;
    } ctl_t;

    ctl_t  ctl_d, ctl_q;
    slot_t tbl0_q [SETS];
    slot_t tbl1_q [SETS];
    logic  fill_q [SETS];

    logic [TAG_W-1:0] req_tag;
    logic [IDX_W-1:0] req_idx, rd_idx;
    logic [OFF_W-1:0] req_off;
    slot_t            rd0, rd1, hw, nw, wr0_d, wr1_d;
    logic             rdf, wrf_d, wr_en_d, accept;
    logic             pr_hit, pr_slot;
    logic             vc_slot, vc_none, vc_wb;
    logic [FRM_W-1:0] vc_frame;

    always_comb begin
        req_tag = req_addr[VA_W-1 -: TAG_W];
        req_idx = req_addr[OFF_W +: IDX_W];
        req_off = req_addr[OFF_W-1:0];
        rd_idx  = ctl_q.busy ? ctl_q.fidx : req_idx;
        rd0     = tbl0_q[rd_idx];
        rd1     = tbl1_q[rd_idx];
        rdf     = fill_q[rd_idx];
    end

    pxu_probe u_probe (.s0(rd0), .s1(rd1), .tag(req_tag), .hit(pr_hit), .slot(pr_slot));

    pxu_victim u_victim (.s0(rd0), .s1(rd1), .last_fill(rdf), .slot(vc_slot),
                         .none(vc_none), .wb(vc_wb), .frame(vc_frame));

    always_comb begin
        accept     = req_valid && !ctl_q.busy;
        ctl_d      = ctl_q;
        ctl_d.rv   = accept;
        ctl_d.hit  = 1'b0;
        ctl_d.fault = 1'b0;
        ctl_d.slot = 1'b0;
        ctl_d.paddr = '0;
        wr_en_d    = 1'b0;
        wr0_d      = rd0;
        wr1_d      = rd1;
        wrf_d      = rdf;
        hw         = pr_slot ? rd1 : rd0;
        nw         = '0;
        if (accept) begin
            if (pr_hit) begin
                ctl_d.hit   = 1'b1;
                ctl_d.slot  = pr_slot;
                ctl_d.paddr = {hw.frame, req_off};
                if (hw.cnt != '1) hw.cnt = hw.cnt + 1'b1;
                if (req_write) hw.dirty = 1'b1;
                wr_en_d = 1'b1;
                if (!pr_slot) wr0_d = hw;
                else if (hw.cnt > rd0.cnt) begin
                    wr0_d = hw;
                    wr1_d = rd0;
                    wrf_d = ~rdf;
                end
                else wr1_d = hw;
            end
            else begin
                ctl_d.fault  = 1'b1;
                ctl_d.busy   = 1'b1;
                ctl_d.ftag   = req_tag;
                ctl_d.fidx   = req_idx;
                ctl_d.vslot  = vc_slot;
                ctl_d.vnone  = vc_none;
                ctl_d.vwb    = vc_wb;
                ctl_d.vframe = vc_frame;
            end
        end
        else if (ctl_q.busy && refill_valid) begin
            ctl_d.busy = 1'b0;
            nw = '{valid: 1'b1, lock: refill_lock, dirty: 1'b0, tag: ctl_q.ftag,
                   frame: refill_frame, cnt: '0};
            if (!ctl_q.vnone) begin
                wr_en_d = 1'b1;
                wrf_d   = ctl_q.vslot;
                if (ctl_q.vslot) wr1_d = nw;
                else             wr0_d = nw;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
            for (int i = 0; i < SETS; i++) begin
                tbl0_q[i] <= '0;
                tbl1_q[i] <= '0;
                fill_q[i] <= 1'b0;
            end
        end
        else begin
            ctl_q <= ctl_d;
            if (wr_en_d) begin
                tbl0_q[rd_idx] <= wr0_d;
                tbl1_q[rd_idx] <= wr1_d;
                fill_q[rd_idx] <= wrf_d;
            end
        end
    end

    assign rsp_valid    = ctl_q.rv;
    assign rsp_hit      = ctl_q.hit;
    assign rsp_fault    = ctl_q.fault;
    assign rsp_slot     = ctl_q.slot;
    assign rsp_paddr    = ctl_q.paddr;
    assign fault_tag    = ctl_q.ftag;
    assign fault_index  = ctl_q.fidx;
    assign busy         = ctl_q.busy;
    assign victim_slot  = ctl_q.vslot;
    assign victim_none  = ctl_q.vnone;
    assign victim_wb    = ctl_q.vwb;
    assign victim_frame = ctl_q.vframe;

    p_one_outcome_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_hit ^ rsp_fault));
    p_fault_holds_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> busy);
    p_quiet_while_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !rsp_valid);
    p_refill_releases_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && refill_valid) |=> !busy);
    p_victim_unpinned_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !pr_hit && !vc_none) |-> !(vc_slot ? rd1.lock : rd0.lock));
    p_none_means_pinned_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !pr_hit && vc_none) |-> (rd0.lock && rd1.lock));
    p_count_saturates_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && pr_hit) |-> (hw.cnt >= (pr_slot ? rd1.cnt : rd0.cnt)));
endmodule

// File: tb/pxu_translate_test.sv
module pxu_translate_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [22:0] req_addr = '0;
    logic        refill_valid = 1'b0, refill_lock = 1'b0;
    logic [5:0]  refill_frame = '0;
    logic        rsp_valid, rsp_hit, rsp_fault, rsp_slot, busy;
    logic [14:0] rsp_paddr;
    logic [4:0]  fault_tag;
    logic [8:0]  fault_index;
    logic        victim_slot, victim_none, victim_wb;
    logic [5:0]  victim_frame;

    int vectors = 0, errors = 0;

    always #10 clk = ~clk;

    pxu_translate uut (.*);

    // behavioural reference
    int mv [512][2], ml [512][2], md [512][2], mt [512][2], mf [512][2], mc [512][2];
    int mlast [512];
    int e_busy = 0, e_rv = 0, e_hit = 0, e_fault = 0, e_slot = 0, e_paddr = 0;
    int e_ftag = 0, e_fidx = 0, e_vslot = 0, e_vnone = 0, e_vwb = 0, e_vframe = 0;

    always @(posedge clk) begin : model
        int tg, ix, of, s, t;
        if (!rst_n) begin
            for (int i = 0; i < 512; i++) begin
                mlast[i] = 0;
                for (int k = 0; k < 2; k++) begin
                    mv[i][k] = 0; ml[i][k] = 0; md[i][k] = 0;
                    mt[i][k] = 0; mf[i][k] = 0; mc[i][k] = 0;
                end
            end
            e_busy = 0; e_rv = 0; e_hit = 0; e_fault = 0; e_slot = 0; e_paddr = 0;
            e_ftag = 0; e_fidx = 0; e_vslot = 0; e_vnone = 0; e_vwb = 0; e_vframe = 0;
        end
        else begin
            e_rv = (req_valid && e_busy == 0) ? 1 : 0;
            e_hit = 0; e_fault = 0; e_slot = 0; e_paddr = 0;
            if (e_rv == 1) begin
                tg = int'(req_addr[22:18]); ix = int'(req_addr[17:9]); of = int'(req_addr[8:0]);
                s = -1;
                if (mv[ix][0] == 1 && mt[ix][0] == tg) s = 0;
                else if (mv[ix][1] == 1 && mt[ix][1] == tg) s = 1;
                if (s >= 0) begin
                    e_hit = 1; e_slot = s; e_paddr = mf[ix][s] * 512 + of;
                    if (mc[ix][s] < 7) mc[ix][s]++;
                    if (req_write) md[ix][s] = 1;
                    if (s == 1 && mc[ix][1] > mc[ix][0]) begin
                        t = mv[ix][0]; mv[ix][0] = mv[ix][1]; mv[ix][1] = t;
                        t = ml[ix][0]; ml[ix][0] = ml[ix][1]; ml[ix][1] = t;
                        t = md[ix][0]; md[ix][0] = md[ix][1]; md[ix][1] = t;
                        t = mt[ix][0]; mt[ix][0] = mt[ix][1]; mt[ix][1] = t;
                        t = mf[ix][0]; mf[ix][0] = mf[ix][1]; mf[ix][1] = t;
                        t = mc[ix][0]; mc[ix][0] = mc[ix][1]; mc[ix][1] = t;
                        mlast[ix] = 1 - mlast[ix];
                    end
                end
                else begin
                    e_fault = 1; e_busy = 1; e_ftag = tg; e_fidx = ix; e_vnone = 0;
                    if (mv[ix][0] == 0) e_vslot = 0;
                    else if (mv[ix][1] == 0) e_vslot = 1;
                    else if (ml[ix][0] == 1 && ml[ix][1] == 1) begin e_vslot = 0; e_vnone = 1; end
                    else if (ml[ix][0] == 1) e_vslot = 1;
                    else if (ml[ix][1] == 1) e_vslot = 0;
                    else if (mc[ix][0] != mc[ix][1]) e_vslot = (mc[ix][0] < mc[ix][1]) ? 0 : 1;
                    else e_vslot = 1 - mlast[ix];
                    if (e_vnone == 1 || mv[ix][e_vslot] == 0) begin e_vwb = 0; e_vframe = 0; end
                    else begin e_vwb = md[ix][e_vslot]; e_vframe = mf[ix][e_vslot]; end
                end
            end
            else if (e_busy == 1 && refill_valid) begin
                e_busy = 0;
                if (e_vnone == 0) begin
                    mv[e_fidx][e_vslot] = 1; ml[e_fidx][e_vslot] = int'(refill_lock);
                    md[e_fidx][e_vslot] = 0; mt[e_fidx][e_vslot] = e_ftag;
                    mf[e_fidx][e_vslot] = int'(refill_frame); mc[e_fidx][e_vslot] = 0;
                    mlast[e_fidx] = e_vslot;
                end
            end
        end
    end

    task automatic chk(string what, string req, int act, int exp);
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        vectors++;
        chk("rsp_valid", "R1", int'(rsp_valid), e_rv);
        chk("rsp_paddr", "R1", int'(rsp_paddr), e_paddr);
        chk("rsp_hit", "R3", int'(rsp_hit), e_hit);
        chk("rsp_fault", "R2", int'(rsp_fault), e_fault);
        chk("busy", "R2", int'(busy), e_busy);
        chk("fault_tag", "R2", int'(fault_tag), e_ftag);
        chk("fault_index", "R2", int'(fault_index), e_fidx);
        chk("rsp_slot", "R9", int'(rsp_slot), e_slot);
        chk("victim_slot", "R7", int'(victim_slot), e_vslot);
        chk("victim_none", "R8", int'(victim_none), e_vnone);
        chk("victim_wb", "R6", int'(victim_wb), e_vwb);
        chk("victim_frame", "R6", int'(victim_frame), e_vframe);
    end

    function automatic logic [22:0] va(int tg, int ix, int of);
        return {tg[4:0], ix[8:0], of[8:0]};
    endfunction

    task automatic cyc(bit v, bit w, logic [22:0] a, bit rf, int fr, bit lk);
        @(negedge clk);
        #1;
        req_valid = v; req_write = w; req_addr = a;
        refill_valid = rf; refill_frame = fr[5:0]; refill_lock = lk;
    endtask

    task automatic idle();
        cyc(0, 0, '0, 0, 0, 0);
    endtask

    task automatic rd(int tg, int ix, int of);
        cyc(1, 0, va(tg, ix, of), 0, 0, 0);
    endtask

    task automatic fill(int fr, bit lk);
        cyc(0, 0, '0, 1, fr, lk);
    endtask

    task automatic miss_fill(int tg, int ix, int fr, bit lk);
        rd(tg, ix, 0); idle(); fill(fr, lk); idle();
    endtask

    initial begin : watchdog
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;                 // R10 reset state checked each clock
        idle();
        // R10: refill while idle is ignored; following request still faults
        fill(9, 0); idle();
        // R2/R7: empty set, victim slot 0; R3 refill then hit (R1 paddr)
        miss_fill(1, 5, 10, 0);
        rd(1, 5, 'h12);
        cyc(1, 1, va(1, 5, 'h1ff), 0, 0, 0);   // R6 write marks dirty
        // R2: request while busy gets no response
        rd(2, 5, 0); rd(2, 5, 4); idle(); fill(20, 0); idle();
        // R4: both pages of set 5 resident; R9 swap after third slot-1 hit
        rd(2, 5, 1); rd(2, 5, 2); rd(2, 5, 3); rd(2, 5, 4); rd(1, 5, 5);
        // R7 lower count, R6 dirty victim reported
        miss_fill(3, 5, 30, 0);
        // R7 tie broken against last refilled slot
        miss_fill(1, 7, 11, 0); miss_fill(2, 7, 12, 0);
        miss_fill(3, 7, 13, 0); miss_fill(4, 7, 14, 0);
        // R5 saturation then tie
        miss_fill(1, 9, 21, 0);
        for (int i = 0; i < 10; i++) rd(1, 9, i);
        miss_fill(2, 9, 22, 0);
        for (int i = 0; i < 8; i++) rd(2, 9, i);
        miss_fill(3, 9, 23, 0);
        // R8 pinned slot skipped, then both pinned
        miss_fill(1, 11, 31, 1); miss_fill(2, 11, 32, 0);
        for (int i = 0; i < 4; i++) rd(2, 11, i);
        miss_fill(3, 11, 33, 1);
        miss_fill(4, 11, 34, 0);
        rd(4, 11, 0); idle();
        // mixed random traffic
        for (int n = 0; n < 400; n++) begin
            if (e_busy == 1 && ($urandom % 3 == 0))
                cyc(0, 0, '0, 1, int'($urandom % 64), ($urandom % 16 == 0));
            else
                cyc(1, ($urandom % 2 == 1), va(int'($urandom % 4), 20 + int'($urandom % 3),
                    int'($urandom % 512)), 0, 0, 0);
        end
        idle(); idle();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule